// File: doc/BRIEF.md
# I2C Register Access Slave

This block sits behind a pair of I2C lines and lets a bus master read and write the bytes of a register file by address. It answers one 7-bit slave address. On a write, the first byte after the address is a register pointer. Each later byte goes out on a single-cycle write strobe to the location the pointer holds, and the pointer then advances by one.

A read begins at the current pointer. The pointer is not cleared by a repeated start, so a master sets it with a short write, issues a repeated start and then reads from there. Each byte is fetched through a single-cycle read strobe, and the pointer advances after the byte has gone out. After reset the pointer is 0, so a read with no pointer ever written starts at register 0.

The low bits of the slave address come from strap inputs; the upper bits are fixed by parameters. A second upper-bit pattern marks a serial memory target. That address is not acknowledged. It only raises a one-cycle flag for whatever logic serves that target.

Top module: `i2c_regport_slave`

## Requirements
- R1: The slave acknowledges (pulls SDA low during the ninth clock) an address byte whose upper 3 bits equal REG_BASE[6:4] (default 3'b010), whose lower 4 bits equal `strap_i`, and whose direction bit is 0 for write or 1 for read.
- R2: An address byte that matches neither window is not acknowledged, and it produces no read strobe, no write strobe and no memory flag.
- R3: An address whose upper bits equal MEM_BASE[6:4] (default 3'b101) and whose low bits equal `strap_i` is not acknowledged. `mem_hit` is high for exactly one clock cycle.
- R4: The first data byte of every write transaction is loaded into the register pointer, is acknowledged, and produces no write strobe.
- R5: Each later written byte is acknowledged and produces one single-cycle `reg_wr` pulse carrying the byte on `reg_wdata` and the pointer on `reg_addr`. The pointer then increments by 1.
- R6: A repeated start leaves the pointer unchanged. Read bytes come from the pointer onward, and the pointer increments by 1 after each byte.
- R7: After reset the pointer is 0, so a read issued before any pointer write returns register 0, then register 1.
- R8: Each read byte is requested by a single-cycle `reg_rd` pulse with the pointer on `reg_addr`. `reg_rdata` is captured one clock after that pulse, and bit 7 is sent first.
- R9: After the master NACKs a read byte, the slave releases SDA and issues no further `reg_rd` until the next start.
- R10: Out of reset, and after every STOP, SDA is released. SDA drive changes only while SCL is low.
- R11: The pointer wraps modulo 2^PTR_W: a write at pointer 8'hFF is followed by a write at 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| strap_i | input | STRAP_W | Low slave address bits from strap pins |
| reg_addr | output | PTR_W | Register address (current pointer) |
| reg_wdata | output | 8 | Write data for the register file |
| reg_wr | output | 1 | Single-cycle register write strobe |
| reg_rd | output | 1 | Single-cycle register read strobe |
| reg_rdata | input | 8 | Read data, valid the cycle after `reg_rd` |
| mem_hit | output | 1 | One-cycle flag: memory target addressed |

## Verification
The assertions check four things on every clock. SDA drive changes only while the synchronized SCL is low. Both strobes last one cycle and never occur together. Each write strobe coincides with the acknowledge drive and is followed by a pointer one higher. A memory hit never comes with SDA drive. Other behaviour can only be shown by the bench's transactions: the pointer load from the first byte, the pointer surviving a repeated start, the start at register 0 after reset, wrap-around at the top of the pointer range, the silence after a read NACK, and the refusal of foreign and memory addresses.

// File: rtl/i2c_rp_pkg.sv
// Shared types for the I2C register access slave.
package i2c_rp_pkg;

    // Byte-level protocol states of the slave controller.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_REQ,
        ST_RD_LOAD,
        ST_RD_BYTE,
        ST_RD_ACK
    } rp_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
// Synchronizes SCL and SDA into the clk domain and derives the bus events.
// Assumes clk is many times faster than SCL, so an edge is at least one
// sampled cycle wide. START and STOP are SDA edges seen while SCL stays high.
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int SR_W = SYNC_STAGES + 1;

    logic [SR_W-1:0] scl_sr;
    logic [SR_W-1:0] sda_sr;
    logic            scl_d;
    logic            sda_d;

    // Shift both lines through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sr <= '1;
            sda_sr <= '1;
        end else begin
            scl_sr <= {scl_sr[SR_W-2:0], scl_i};
            sda_sr <= {sda_sr[SR_W-2:0], sda_i};
        end
    end

    assign scl_s = scl_sr[SYNC_STAGES-1];
    assign sda_s = sda_sr[SYNC_STAGES-1];
    assign scl_d = scl_sr[SYNC_STAGES];
    assign sda_d = sda_sr[SYNC_STAGES];

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_reg_pointer.sv
// Register pointer: loaded from the first written byte and stepped after
// each transferred byte. Wraps modulo 2^PTR_W. Cleared only by reset.
module i2c_reg_pointer #(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             inc,
    output logic [PTR_W-1:0] ptr
);

    // Hold, load or step the pointer; a load wins over a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (inc) begin
            ptr <= ptr + 1'b1;
        end
    end

endmodule

// File: rtl/i2c_rp_ctrl.sv
// Byte-level slave controller. It decodes the address, drives the
// acknowledges and read bits, and issues register strobes and pointer
// commands. Assumes bus events come from i2c_line_sync and that reg_rdata
// is valid the cycle after reg_rd. START and STOP override every state.
module i2c_rp_ctrl
    import i2c_rp_pkg::*;
#(
    parameter int         STRAP_W  = 4,
    parameter logic [6:0] REG_BASE = 7'h20,
    parameter logic [6:0] MEM_BASE = 7'h50
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sda_s,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [7:0]         reg_rdata,
    output logic               sda_oe,
    output logic               reg_wr,
    output logic               reg_rd,
    output logic [7:0]         reg_wdata,
    output logic               ptr_load,
    output logic               ptr_inc,
    output logic               mem_hit
);

    localparam int BIT_CNT_W = 4;
    localparam logic [BIT_CNT_W-1:0] BYTE_BITS = BIT_CNT_W'(8);
    localparam logic [BIT_CNT_W-1:0] LAST_OUT  = BIT_CNT_W'(7);

    rp_state_e            state;
    logic [7:0]           sh;
    logic [BIT_CNT_W-1:0] cnt;
    logic                 rnw;
    logic                 first;
    logic                 more;
    logic                 reg_match;
    logic                 mem_match;

    // Compare the received address against both windows.
    always_comb begin
        reg_match = (sh[7:STRAP_W+1] == REG_BASE[6:STRAP_W]) &&
                    (sh[STRAP_W:1] == strap_i);
        mem_match = (sh[7:STRAP_W+1] == MEM_BASE[6:STRAP_W]) &&
                    (sh[STRAP_W:1] == strap_i);
    end

    assign reg_rd = (state == ST_RD_REQ);

    // Protocol sequencer: shifts bits, answers bytes, emits strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            sh        <= '0;
            cnt       <= '0;
            rnw       <= 1'b0;
            first     <= 1'b0;
            more      <= 1'b0;
            sda_oe    <= 1'b0;
            reg_wr    <= 1'b0;
            reg_wdata <= '0;
            ptr_load  <= 1'b0;
            ptr_inc   <= 1'b0;
            mem_hit   <= 1'b0;
        end else begin
            reg_wr   <= 1'b0;
            ptr_load <= 1'b0;
            ptr_inc  <= 1'b0;
            mem_hit  <= 1'b0;
            if (start_det) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            sh  <= {sh[6:0], sda_s};
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall && cnt == BYTE_BITS) begin
                            if (reg_match) begin
                                sda_oe <= 1'b1;
                                rnw    <= sh[0];
                                state  <= ST_ADDR_ACK;
                            end else begin
                                mem_hit <= mem_match;
                                state   <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            if (rnw) begin
                                state <= ST_RD_REQ;
                            end else begin
                                sda_oe <= 1'b0;
                                cnt    <= '0;
                                first  <= 1'b1;
                                state  <= ST_WR_BYTE;
                            end
                        end
                    end
                    ST_WR_BYTE: begin
                        if (scl_rise) begin
                            sh  <= {sh[6:0], sda_s};
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall && cnt == BYTE_BITS) begin
                            sda_oe    <= 1'b1;
                            reg_wdata <= sh;
                            if (first) begin
                                ptr_load <= 1'b1;
                                first    <= 1'b0;
                            end else begin
                                reg_wr  <= 1'b1;
                                ptr_inc <= 1'b1;
                            end
                            state <= ST_WR_ACK;
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            state  <= ST_WR_BYTE;
                        end
                    end
                    ST_RD_REQ: begin
                        state <= ST_RD_LOAD;
                    end
                    ST_RD_LOAD: begin
                        sh     <= reg_rdata;
                        sda_oe <= ~reg_rdata[7];
                        cnt    <= '0;
                        state  <= ST_RD_BYTE;
                    end
                    ST_RD_BYTE: begin
                        if (scl_fall) begin
                            if (cnt == LAST_OUT) begin
                                sda_oe  <= 1'b0;
                                ptr_inc <= 1'b1;
                                state   <= ST_RD_ACK;
                            end else begin
                                sda_oe <= ~sh[6];
                                sh     <= {sh[6:0], 1'b0};
                                cnt    <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            more <= ~sda_s;
                        end else if (scl_fall) begin
                            state <= more ? ST_RD_REQ : ST_IDLE;
                        end
                    end
                    default: begin
                        state <= ST_IDLE;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_regport_slave.sv
// Top of the I2C register access slave. Ties the line synchronizer, the
// protocol controller and the register pointer together. Assumes an
// external open-drain SDA pad driven low while sda_oe is 1.
module i2c_regport_slave #(
    parameter int         STRAP_W     = 4,
    parameter int         PTR_W       = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] REG_BASE    = 7'h20,
    parameter logic [6:0] MEM_BASE    = 7'h50
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] strap_i,
    output logic [PTR_W-1:0]   reg_addr,
    output logic [7:0]         reg_wdata,
    output logic               reg_wr,
    output logic               reg_rd,
    input  logic [7:0]         reg_rdata,
    output logic               mem_hit
);

    logic scl_s;
    logic sda_s;
    logic scl_rise;
    logic scl_fall;
    logic start_det;
    logic stop_det;
    logic ptr_load;
    logic ptr_inc;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_rp_ctrl #(
        .STRAP_W  (STRAP_W),
        .REG_BASE (REG_BASE),
        .MEM_BASE (MEM_BASE)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .strap_i   (strap_i),
        .reg_rdata (reg_rdata),
        .sda_oe    (sda_oe),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .ptr_load  (ptr_load),
        .ptr_inc   (ptr_inc),
        .mem_hit   (mem_hit)
    );

    i2c_reg_pointer #(.PTR_W(PTR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (reg_wdata[PTR_W-1:0]),
        .inc      (ptr_inc),
        .ptr      (reg_addr)
    );

endmodule

// File: rtl/i2c_rp_chk.sv
// Protocol checker for i2c_regport_slave, attached through bind.
module i2c_rp_chk #(
    parameter int PTR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             sda_oe,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic             mem_hit,
    input logic [PTR_W-1:0] reg_addr
);

    // R10
    sda_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_s));

    // R5
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    // R5
    wr_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> sda_oe);

    // R11
    wr_ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> reg_addr == PTR_W'($past(reg_addr) + 1'b1));

    // R8
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    // R8
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr));

    // R3
    mem_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_hit |-> !sda_oe);

endmodule

bind i2c_regport_slave i2c_rp_chk #(.PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_oe   (sda_oe),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .mem_hit  (mem_hit),
    .reg_addr (reg_addr)
);

// File: tb/tb_i2c_regport_slave.sv
// Scoreboard bench: a bus-master model drives transactions, expected
// register writes go into a queue, and a monitor pops and compares them.
module tb_i2c_regport_slave;

    localparam int H = 25;
    localparam logic [3:0] STRAP = 4'b0110;
    localparam logic [6:0] A_REG = 7'h26;
    localparam logic [6:0] A_MEM = 7'h56;
    localparam logic [6:0] A_BAD = 7'h27;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe;
    logic [7:0] reg_addr;
    logic [7:0] reg_wdata;
    logic reg_wr;
    logic reg_rd;
    logic [7:0] reg_rdata;
    logic mem_hit;
    logic [7:0] rf [256];
    logic [15:0] exp_q [$];
    int nchk = 0;
    int nfail = 0;
    int rd_cnt = 0;
    int mem_cnt = 0;
    int sda_viol = 0;
    logic done = 1'b0;
    logic oe_prev = 1'b0;
    logic scl_prev = 1'b1;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_regport_slave dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .strap_i   (STRAP),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata),
        .mem_hit   (mem_hit)
    );

    // Register file model: preset pattern, registered read.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) rf[i] <= 8'(i) ^ 8'h5A;
            reg_rdata <= '0;
        end else begin
            if (reg_wr) rf[reg_addr] <= reg_wdata;
            if (reg_rd) reg_rdata <= rf[reg_addr];
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pop expected writes and compare; count strobes and SDA changes.
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_wr) begin
                if (exp_q.size() == 0) begin
                    check("R5 unexpected write strobe", 1, 0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check("R5 write address", 32'(reg_addr), 32'(e[15:8]));
                    check("R5 write data", 32'(reg_wdata), 32'(e[7:0]));
                end
            end
            if (reg_rd) rd_cnt++;
            if (mem_hit) mem_cnt++;
            if (sda_oe !== oe_prev && scl_m && scl_prev) sda_viol++;
        end
        oe_prev  = sda_oe;
        scl_prev = scl_m;
    end

    task automatic hw();
        repeat (H) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hw();
        scl_m = 1'b1; hw();
        sda_m = 1'b0; hw();
        scl_m = 1'b0; hw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hw();
        scl_m = 1'b1; hw();
        sda_m = 1'b1; hw();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hw();
            scl_m = 1'b1; hw();
            scl_m = 1'b0;
        end
        sda_m = 1'b1; hw();
        scl_m = 1'b1; hw();
        ack = ~sda_line;
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            hw();
            scl_m = 1'b1; hw();
            b = {b[6:0], sda_line};
            scl_m = 1'b0;
        end
        sda_m = nack; hw();
        scl_m = 1'b1; hw();
        scl_m = 1'b0; hw();
        sda_m = 1'b1;
    endtask

    // Expect a write strobe for (addr, data).
    task automatic expect_wr(input logic [7:0] a, input logic [7:0] d);
        exp_q.push_back({a, d});
    endtask

    initial begin
        logic ack;
        logic [7:0] b;
        int rd0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R10: reset state
        check("R10 sda released after reset", 32'(sda_oe), 0);
        check("R8 no read strobe after reset", 32'(reg_rd), 0);
        check("R3 no mem flag after reset", 32'(mem_hit), 0);

        // R7: read without pointer starts at register 0
        bus_start();
        send_byte({A_REG, 1'b1}, ack);
        check("R1 read address acked", 32'(ack), 1);
        recv_byte(1'b0, b);
        check("R7 first read from reg 0", 32'(b), 32'h5A);
        recv_byte(1'b1, b);
        check("R6 second read from reg 1", 32'(b), 32'h5B);
        hw();
        check("R9 released after nack", 32'(sda_oe), 0);
        check("R9 exactly two read strobes", 32'(rd_cnt), 2);
        bus_stop();
        check("R10 sda released after stop", 32'(sda_oe), 0);

        // R4/R5: pointer load then sequential writes
        bus_start();
        send_byte({A_REG, 1'b0}, ack);
        check("R1 write address acked", 32'(ack), 1);
        send_byte(8'h10, ack);
        check("R4 pointer byte acked", 32'(ack), 1);
        expect_wr(8'h10, 8'hA1);
        send_byte(8'hA1, ack);
        check("R5 data byte acked", 32'(ack), 1);
        expect_wr(8'h11, 8'hB2);
        send_byte(8'hB2, ack);
        expect_wr(8'h12, 8'hC3);
        send_byte(8'hC3, ack);
        check("R5 last byte acked", 32'(ack), 1);
        bus_stop();

        // R6: set pointer, repeated start, read back
        bus_start();
        send_byte({A_REG, 1'b0}, ack);
        send_byte(8'h11, ack);
        rd0 = rd_cnt;
        bus_start();
        send_byte({A_REG, 1'b1}, ack);
        check("R6 read after restart acked", 32'(ack), 1);
        recv_byte(1'b0, b);
        check("R6 read at pointer", 32'(b), 32'hB2);
        recv_byte(1'b1, b);
        check("R6 read at pointer+1", 32'(b), 32'hC3);
        bus_stop();
        check("R8 one strobe per read byte", 32'(rd_cnt - rd0), 2);

        // R11: pointer wrap
        bus_start();
        send_byte({A_REG, 1'b0}, ack);
        send_byte(8'hFF, ack);
        expect_wr(8'hFF, 8'h77);
        send_byte(8'h77, ack);
        expect_wr(8'h00, 8'h88);
        send_byte(8'h88, ack);
        bus_stop();

        // R2: foreign address ignored
        rd0 = rd_cnt;
        bus_start();
        send_byte({A_BAD, 1'b1}, ack);
        check("R2 foreign address not acked", 32'(ack), 0);
        bus_stop();
        check("R2 no strobe for foreign address", 32'(rd_cnt - rd0), 0);
        check("R2 no mem flag for foreign address", 32'(mem_cnt), 0);

        // R3: memory window flagged, not acked
        bus_start();
        send_byte({A_MEM, 1'b0}, ack);
        check("R3 memory address not acked", 32'(ack), 0);
        bus_stop();
        check("R3 one mem flag pulse", 32'(mem_cnt), 1);

        hw();
        check("R5 all expected writes seen", 32'(exp_q.size()), 0);
        check("R10 sda changed only with scl low", 32'(sda_viol), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
            $finish;
        end
    end

endmodule